// File: doc/BRIEF.md
# Port Edge Interrupt Monitor

This block watches a set of small input ports (two ports of four pins by default) and raises one interrupt request per port when an enabled pin shows the chosen signal edge. Each port is set up through two 4-bit registers on a simple I/O-mapped bus. A priority register holds an active-low mask, an edge-polarity select and a 2-bit priority code. A pin-enable register holds one active-low enable per pin.

Pin inputs pass through a two-flop synchronizer before edges are detected. A detected edge latches a per-port pending flag. The flag stays set until the CPU pulses that port's acknowledge line, or until software writes either register of the port. The request output is the pending flag qualified by the mask. Next to the request, the block presents a 3-bit level decoded from the priority code, so that a downstream arbiter can rank the ports.

Top module: `pem_unit`

## Requirements
- R1: After reset, both registers of every port read back as 4'b1111, the requests are low, and the level output of each port is 1.
- R2: The level output follows priority-register bits [1:0] on the cycle after the write: code 00 gives 7, 01 gives 5, 10 gives 3 and 11 gives 1.
- R3: The request of a port is high only while priority-register bit 3 (mask) is 0. With the mask set to 1, the request stays low even after a qualifying edge.
- R4: Priority-register bit 2 selects the edge: 1 reacts to a rising edge, 0 to a falling edge. The opposite edge raises nothing.
- R5: Pin-enable register bit n governs pin n: 0 lets the pin raise the request and 1 blocks it.
- R6: Once raised, a request stays high without further edges until the port's acknowledge input is pulsed. The pulse clears it on the next clock.
- R7: A write to either register of a port clears that port's pending request.
- R8: Reprogramming alone never raises a request. Enabling a pin that is already at the selected level, or flipping the polarity while the pins are steady, leaves the request low.
- R9: The priority register of port p is the primary register (aux_sel=0) at address BASE_ADDR+p, and its pin-enable register is the auxiliary register (aux_sel=1) at the same address. Reads return the register zero-extended to the bus width. A read of an unmapped address returns 0, and a write to it changes no register.
- R10: Ports are independent. An edge, acknowledge or write on one port does not change the request of another.
- R11: A pin change applied before clock edge k sets the request after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins | input | N_PORTS*PIN_W | Asynchronous port pins, port p at [p*PIN_W +: PIN_W] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| aux_sel | input | 1 | 0 selects the priority register, 1 selects the pin-enable register |
| wdata | input | max(PIN_W,4) | Write data |
| rdata | output | DATA_W | Read data, zero when not reading |
| ack | input | N_PORTS | Per-port acknowledge pulse |
| irq | output | N_PORTS | Per-port interrupt request |
| irq_lvl | output | 3*N_PORTS | Per-port decoded level, port p at [3p +: 3] |

## Verification
The bench builds the block with its defaults: two ports of four pins, BASE_ADDR 2, a 4-bit address and an 8-bit read bus. Two ports are enough to show that an edge, acknowledge or write on one port leaves the other alone. With BASE_ADDR 2 the unmapped addresses lie on both sides of the mapped pair, and the 8-bit read bus shows the zero-extension of the 4-bit registers.

// File: rtl/pem_pkg.sv
// Package: shared types and decode helpers for the port edge monitor.
// Assumes the priority register is always four bits: mask, edge, 2-bit code.
package pem_pkg;

    localparam int PRIO_W = 4;
    localparam int LVL_W  = 3;

    typedef struct packed {
        logic       mask_n_dis; // 1 = port request blocked
        logic       rise_sel;   // 1 = rising edge, 0 = falling edge
        logic [1:0] code;       // priority code
    } prio_t;

    // Map the 2-bit code onto odd levels 7,5,3,1
    function automatic logic [LVL_W-1:0] code_to_level(input logic [1:0] c);
        return LVL_W'(3'd7 - {c, 1'b0});
    endfunction

endpackage

// File: rtl/pem_sync.sv
// Module: multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit is independent (no bus coherence needed across bits).
module pem_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Shift toward the output
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pem_edge.sv
// Module: edge detector over synchronized pins with per-pin active-low enables.
// Assumes smp is already synchronous to clk. The history register follows
// smp every cycle, so a static level never produces a hit.
module pem_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic         rise_sel,
    input  logic [W-1:0] en_n,
    output logic         hit
);
    logic [W-1:0] hist_q;
    logic [W-1:0] edges;

    // Remember last cycle's synchronized pins
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= smp;
    end

    // Select the edge direction and keep enabled pins only
    always_comb begin
        edges = rise_sel ? (smp & ~hist_q) : (~smp & hist_q);
        hit   = |(edges & ~en_n);
    end
endmodule

// File: rtl/pem_port.sv
// Module: one monitored port with its two registers, edge detector and
// pending flag. Assumes write strobes are already decoded for this port.
// Priority of pending updates: register write clears, then edge sets,
// then acknowledge clears.
module pem_port
    import pem_pkg::*;
#(
    parameter int PIN_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PIN_W-1:0]    smp,
    input  logic                wr_prio,
    input  logic                wr_aux,
    input  logic [PRIO_W-1:0]   wd_prio,
    input  logic [PIN_W-1:0]    wd_aux,
    input  logic                ack,
    output logic [PRIO_W-1:0]   prio_bits,
    output logic [PIN_W-1:0]    aux_bits,
    output logic                irq,
    output logic [LVL_W-1:0]    lvl
);
    prio_t            prio_q;
    logic [PIN_W-1:0] aux_q;
    logic             pend_q;
    logic             hit;
    logic             wr_any;

    assign wr_any = wr_prio | wr_aux;

    // Register file for this port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= prio_t'(4'hF);
            aux_q  <= '1;
        end else begin
            if (wr_prio) prio_q <= prio_t'(wd_prio);
            if (wr_aux)  aux_q  <= wd_aux;
        end
    end

    pem_edge #(.W(PIN_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (smp),
        .rise_sel (prio_q.rise_sel),
        .en_n     (aux_q),
        .hit      (hit)
    );

    // Pending flag: cleared by reprogramming, set by edge, cleared by ack
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (wr_any) pend_q <= 1'b0;
        else if (hit)    pend_q <= 1'b1;
        else if (ack)    pend_q <= 1'b0;
    end

    // Output qualification and level decode
    always_comb begin
        irq       = pend_q & ~prio_q.mask_n_dis;
        lvl       = code_to_level(prio_q.code);
        prio_bits = prio_q;
        aux_bits  = aux_q;
    end

    p_wr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> !pend_q);
    p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_any) |=> pend_q);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit && !wr_any) |=> !pend_q);
    p_pend_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack && !wr_any) |=> pend_q);
    p_no_hit_when_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&aux_q) |-> !hit);
endmodule

// File: rtl/pem_unit.sv
// Module: top of the port edge monitor. Decodes the register bus, instantiates
// a synchronizer and a port slice per port, and muxes read data.
// Assumes DATA_W is at least the register width; reads are combinational.
module pem_unit
    import pem_pkg::*;
#(
    parameter int N_PORTS   = 2,
    parameter int PIN_W     = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int BASE_ADDR = 2,
    parameter int SYNC_STG  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_PORTS*PIN_W-1:0]     pins,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         aux_sel,
    input  logic [(PIN_W>4?PIN_W:4)-1:0] wdata,
    output logic [DATA_W-1:0]            rdata,
    input  logic [N_PORTS-1:0]           ack,
    output logic [N_PORTS-1:0]           irq,
    output logic [N_PORTS*LVL_W-1:0]     irq_lvl
);
    logic [N_PORTS-1:0][PRIO_W-1:0] prio_bits;
    logic [N_PORTS-1:0][PIN_W-1:0]  aux_bits;
    logic [N_PORTS-1:0]             sel;
    logic                           any_sel;

    // Address decode per port
    always_comb begin
        for (int p = 0; p < N_PORTS; p++)
            sel[p] = (addr == ADDR_W'(BASE_ADDR + p));
        any_sel = |sel;
    end

    genvar g;
    generate
        for (g = 0; g < N_PORTS; g++) begin : g_port
            logic [PIN_W-1:0] smp;

            pem_sync #(.W(PIN_W), .STAGES(SYNC_STG)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pins[g*PIN_W +: PIN_W]),
                .q     (smp)
            );

            pem_port #(.PIN_W(PIN_W)) u_port (
                .clk       (clk),
                .rst_n     (rst_n),
                .smp       (smp),
                .wr_prio   (wr_en & sel[g] & ~aux_sel),
                .wr_aux    (wr_en & sel[g] & aux_sel),
                .wd_prio   (wdata[PRIO_W-1:0]),
                .wd_aux    (wdata[PIN_W-1:0]),
                .ack       (ack[g]),
                .prio_bits (prio_bits[g]),
                .aux_bits  (aux_bits[g]),
                .irq       (irq[g]),
                .lvl       (irq_lvl[g*LVL_W +: LVL_W])
            );
        end
    endgenerate

    // Read mux: addressed register, zero-extended; zero otherwise
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int p = 0; p < N_PORTS; p++) begin
                if (sel[p])
                    rdata = aux_sel ? DATA_W'(aux_bits[p]) : DATA_W'(prio_bits[p]);
            end
        end
    end

    p_unmapped_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_sel) |-> (rdata == '0));
    p_unmapped_write_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_sel) |=> ($stable(prio_bits) && $stable(aux_bits)));
endmodule

// File: tb/sim_pem_unit.sv
module sim_pem_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int PW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP*PW-1:0] pins = '0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [3:0]     addr = '0;
    logic           aux_sel = 1'b0;
    logic [3:0]     wdata = '0;
    logic [7:0]     rdata;
    logic [NP-1:0]  ack = '0;
    logic [NP-1:0]  irq;
    logic [NP*3-1:0] irq_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pem_unit u0 (
        .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .aux_sel(aux_sel), .wdata(wdata), .rdata(rdata),
        .ack(ack), .irq(irq), .irq_lvl(irq_lvl)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input bit aux, input int d);
        addr = 4'(a); aux_sel = aux; wdata = 4'(d); wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input bit aux, output int v);
        addr = 4'(a); aux_sel = aux; rd_en = 1'b1;
        #1 v = int'(rdata);
        rd_en = 1'b0;
    endtask

    task automatic pulse_ack(input int p);
        ack[p] = 1'b1;
        @(posedge clk); @(negedge clk);
        ack[p] = 1'b0;
    endtask

    function automatic int lvl(input int p);
        return int'(irq_lvl[p*3 +: 3]);
    endfunction

    task automatic t_reset();
        int v;
        for (int p = 0; p < NP; p++) begin
            rd(2 + p, 0, v); chk("R1 prio reset", v, 15);
            rd(2 + p, 1, v); chk("R1 aux reset", v, 15);
            chk("R1 level reset", lvl(p), 1);
        end
        chk("R1 irq reset", int'(irq), 0);
    endtask

    task automatic t_levels();
        int exp_l[4] = '{7, 5, 3, 1};
        for (int c = 0; c < 4; c++) begin
            wr(2, 0, 4 + c);
            chk("R2 level decode", lvl(0), exp_l[c]);
        end
    endtask

    task automatic t_rising();
        wr(2, 1, 4'b0000);
        wr(2, 0, 4'b0100);
        pins[0] = 1'b1;
        cyc(2); chk("R11 not yet set", int'(irq[0]), 0);
        cyc(1); chk("R11 set after sync", int'(irq[0]), 1);
        pulse_ack(0); chk("R6 ack clears", int'(irq[0]), 0);
        pins[0] = 1'b0;
        cyc(4); chk("R4 falling ignored on rising", int'(irq[0]), 0);
    endtask

    task automatic t_falling();
        wr(2, 0, 4'b0000);
        pins[1] = 1'b1;
        cyc(4); chk("R4 rising ignored on falling", int'(irq[0]), 0);
        pins[1] = 1'b0;
        cyc(4); chk("R4 falling edge raises", int'(irq[0]), 1);
        pulse_ack(0); chk("R6 ack clears falling", int'(irq[0]), 0);
    endtask

    task automatic t_enable();
        wr(2, 1, 4'b1110);
        wr(2, 0, 4'b0100);
        pins[2] = 1'b1;
        cyc(4); chk("R5 disabled pin ignored", int'(irq[0]), 0);
        pins[0] = 1'b1;
        cyc(4); chk("R5 enabled pin raises", int'(irq[0]), 1);
        pulse_ack(0);
    endtask

    task automatic t_mask();
        wr(2, 0, 4'b1100);
        pins[0] = 1'b0; cyc(4);
        pins[0] = 1'b1; cyc(4);
        chk("R3 masked no request", int'(irq[0]), 0);
        wr(2, 0, 4'b0100);
        chk("R3 unmask after write stays low", int'(irq[0]), 0);
    endtask

    task automatic t_hold_and_clear();
        pins[0] = 1'b0; cyc(4);
        pins[0] = 1'b1; cyc(4);
        chk("R6 request raised", int'(irq[0]), 1);
        cyc(10); chk("R6 request held", int'(irq[0]), 1);
        wr(2, 1, 4'b1110);
        chk("R7 aux write clears", int'(irq[0]), 0);
        cyc(5); chk("R7 stays cleared", int'(irq[0]), 0);
        pins[0] = 1'b0; cyc(4);
        wr(2, 0, 4'b0000);
        pins[0] = 1'b1; cyc(4); pins[0] = 1'b0; cyc(4);
        chk("R7 falling raised", int'(irq[0]), 1);
        wr(2, 0, 4'b0000);
        chk("R7 prio write clears", int'(irq[0]), 0);
    endtask

    task automatic t_no_self();
        pins[0] = 1'b1; cyc(4);
        wr(2, 1, 4'b1111);
        wr(2, 0, 4'b0100);
        wr(2, 1, 4'b1110);
        cyc(5); chk("R8 enabling high pin", int'(irq[0]), 0);
        wr(2, 0, 4'b0000);
        cyc(5); chk("R8 polarity flip", int'(irq[0]), 0);
        wr(2, 0, 4'b0100);
        cyc(5); chk("R8 polarity back", int'(irq[0]), 0);
    endtask

    task automatic t_ports();
        wr(3, 1, 4'b0111);
        wr(3, 0, 4'b0110);
        chk("R10 port B level", lvl(1), 3);
        chk("R10 port A level kept", lvl(0), 7);
        pins[PW + 0] = 1'b1;
        cyc(4); chk("R5 port B disabled pin", int'(irq[1]), 0);
        pins[PW + 3] = 1'b1;
        cyc(4); chk("R10 port B raises", int'(irq[1]), 1);
        chk("R10 port A untouched", int'(irq[0]), 0);
        pulse_ack(0); chk("R10 ack A keeps B", int'(irq[1]), 1);
        wr(2, 1, 4'b1110); chk("R10 write A keeps B", int'(irq[1]), 1);
        pulse_ack(1); chk("R6 ack B clears", int'(irq[1]), 0);
    endtask

    task automatic t_map();
        int v;
        wr(5, 0, 4'b1010);
        wr(1, 1, 4'b1010);
        rd(2, 0, v); chk("R9 port A prio", v, 4);
        rd(2, 1, v); chk("R9 port A aux", v, 14);
        rd(3, 0, v); chk("R9 port B prio", v, 6);
        rd(3, 1, v); chk("R9 port B aux zero-ext", v, 7);
        rd(5, 0, v); chk("R9 unmapped read", v, 0);
        rd(1, 1, v); chk("R9 unmapped aux read", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();
        t_rising();
        t_falling();
        t_enable();
        t_mask();
        t_hold_and_clear();
        t_no_self();
        t_ports();
        t_map();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule